// File: doc/BRIEF.md
# Credit-Based Transmit Eligibility Unit

This unit decides, one request per clock, whether a cell waiting in a flow-controlled priority class may leave on an outgoing link. Such a cell needs two credits at the same moment: one from the receiver's buffer pool for that link, and one for the flow group its connection belongs to. When both are available the cell is granted and each counter drops by one. When either is missing the cell is denied and nothing changes. The requester keeps the cell queued and asks again later, so no cell is ever dropped. Priority classes whose enable bit is clear skip the check altogether.

Credits come back from the far end as four link characters: a control character carrying the credit code, then three data characters. The unit unpacks these and adds one to the counter each credit names, never going above that counter's start value. Sequences that are broken, out of order or carry bad fields are thrown away and flagged. In the other direction, the unit packs locally generated credits into the same four-character form for the transmitter.

Top module: `credit_gate`

## Requirements
- R1: In reset and on the first cycle after it, gnt_valid, tx_valid, tx_busy and rx_err are low. Every pool counter starts at POOL_INIT and every flow-group counter at FG_INIT.
- R2: A request sampled on an edge gives gnt_valid high right after that edge, and only then. For a class with backpressure enabled, gnt_ok is 1 exactly when the pool counter of req_link and the flow-group counter of (req_link, req_fg) are both non-zero.
- R3: A granted backpressured request lowers both of those counters by one on the same edge.
- R4: A request whose req_prio has its bp_en bit clear is always granted and changes no counter. A priority value of NPRIO or above counts as backpressured.
- R5: A denied request leaves every counter unchanged, so the same request is denied again until a credit arrives.
- R6: A credit sequence is the control character 0xC5 (rx_k=1) followed by three data characters (rx_k=0). Byte 1 is {kind, 3'b000, link[3:0]}, with kind 1 for pool and 0 for flow group. Byte 2 is {4'b0000, fg[11:8]} and byte 3 is fg[7:0]. On the edge that samples byte 3, the named counter rises by one.
- R7: A credit that would take a counter above its start value leaves it at the start value.
- R8: rx_err pulses high right after the edge that samples a bad character, and no counter changes. Bad characters are: a data character with no sequence open; any control character while a sequence is open (a 0xC5 then opens a new sequence); and a byte 3 whose reserved bits are non-zero, whose link is N_LINKS or above, or whose fg does not fit in FG_W bits. A control character other than 0xC5 with no sequence open is ignored.
- R9: A tx_req sampled while tx_busy is low puts out four characters on the next four cycles: 0xC5 with tx_k=1, then the three R6 bytes with tx_k=0. tx_busy is high while the header and the first two data bytes are on the output. Requests during that time are ignored. A request taken in the cycle the last byte shows follows with no gap.
- R10: A grant and a flow-group credit that hit the same counter on the same edge leave that counter at its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bp_en | input | NPRIO | Backpressure enable, one bit per priority |
| req_valid | input | 1 | Transmit request present |
| req_link | input | LINK_W | Outgoing link of the cell |
| req_prio | input | PRIO_W | Priority class of the cell |
| req_fg | input | FG_W | Flow group of the cell |
| gnt_valid | output | 1 | Decision present |
| gnt_ok | output | 1 | 1 = send, 0 = keep queued |
| rx_valid | input | 1 | Received character present |
| rx_k | input | 1 | Received character is a control character |
| rx_data | input | 8 | Received character |
| rx_err | output | 1 | Malformed credit sequence seen |
| tx_req | input | 1 | Request to send a credit |
| tx_pool | input | 1 | Credit kind, 1 = pool |
| tx_link | input | LINK_W | Link field of the credit to send |
| tx_fg | input | FG_W | Flow group field of the credit to send |
| tx_valid | output | 1 | Outgoing character present |
| tx_k | output | 1 | Outgoing character is a control character |
| tx_data | output | 8 | Outgoing character |
| tx_busy | output | 1 | Packer cannot take a request |

## Verification
A counter that holds the wrong value stays hidden until a request reaches it. It then shows up as a wrong gnt_ok right after that edge. A counter that is too high shows as one grant too many when it is drained, and one that is too low shows as an early deny. So the directed tests drain chosen counters to zero and refill them on purpose, and a reference model follows every counter through the random traffic. A parser that loses its place shows up right away as a wrong rx_err pulse, or later as a credit that is missing or counted twice when its counter is next drained.

// File: rtl/cg_pkg.sv
package cg_pkg;
  localparam int CHAR_W      = 8;
  localparam int WIRE_FG_W   = 12;
  localparam int WIRE_LINK_W = 4;
  localparam logic [CHAR_W-1:0] CREDIT_K = 8'hC5;

  typedef enum logic [1:0] {
    RX_HDR = 2'd0,
    RX_B1  = 2'd1,
    RX_B2  = 2'd2,
    RX_B3  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/cg_rx_unpack.sv
module cg_rx_unpack
  import cg_pkg::*;
#(
  parameter int N_LINKS = 4,
  parameter int FG_W    = 8,
  localparam int LINK_W = (N_LINKS > 1) ? $clog2(N_LINKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_k,
  input  logic [CHAR_W-1:0] rx_data,
  output logic              cr_valid,
  output logic              cr_pool,
  output logic [LINK_W-1:0] cr_link,
  output logic [FG_W-1:0]   cr_fg,
  output logic              err
);
  localparam logic [WIRE_LINK_W:0] LINK_LIM = (WIRE_LINK_W+1)'(N_LINKS);

  rx_state_e             st;
  logic [CHAR_W-1:0]     b1, b2;
  logic [WIRE_LINK_W-1:0] f_link;
  logic [WIRE_FG_W-1:0]  f_fg;
  logic                  is_hdr, last, fields_ok, bad;

  assign is_hdr    = rx_valid && rx_k && (rx_data == CREDIT_K);
  assign f_link    = b1[WIRE_LINK_W-1:0];
  assign f_fg      = {b2[3:0], rx_data};
  assign last      = rx_valid && !rx_k && (st == RX_B3);
  assign fields_ok = (b1[6:4] == 3'b000) && (b2[7:4] == 4'b0000) &&
                     ({1'b0, f_link} < LINK_LIM) && ((f_fg >> FG_W) == '0);
  assign bad       = rx_valid && ((!rx_k && st == RX_HDR) ||
                                  (rx_k && st != RX_HDR) ||
                                  (last && !fields_ok));

  assign cr_valid = last && fields_ok;
  assign cr_pool  = b1[7];
  assign cr_link  = f_link[LINK_W-1:0];
  assign cr_fg    = f_fg[FG_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= RX_HDR;
      b1  <= '0;
      b2  <= '0;
      err <= 1'b0;
    end else begin
      err <= bad;
      if (rx_valid) begin
        if (rx_k) begin
          st <= is_hdr ? RX_B1 : RX_HDR;
        end else begin
          unique case (st)
            RX_HDR: st <= RX_HDR;
            RX_B1: begin
              b1 <= rx_data;
              st <= RX_B2;
            end
            RX_B2: begin
              b2 <= rx_data;
              st <= RX_B3;
            end
            RX_B3: st <= RX_HDR;
            default: st <= RX_HDR;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cg_tx_pack.sv
module cg_tx_pack
  import cg_pkg::*;
#(
  parameter int N_LINKS = 4,
  parameter int FG_W    = 8,
  localparam int LINK_W = (N_LINKS > 1) ? $clog2(N_LINKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_req,
  input  logic              tx_pool,
  input  logic [LINK_W-1:0] tx_link,
  input  logic [FG_W-1:0]   tx_fg,
  output logic              tx_valid,
  output logic              tx_k,
  output logic [CHAR_W-1:0] tx_data,
  output logic              tx_busy
);
  logic [2:0]             ph;
  logic [CHAR_W-1:0]      h1, h2, h3;
  logic [WIRE_FG_W-1:0]   fg12;
  logic [WIRE_LINK_W-1:0] link4;
  logic                   accept;

  assign fg12    = WIRE_FG_W'(tx_fg);
  assign link4   = WIRE_LINK_W'(tx_link);
  assign accept  = tx_req && (ph == 3'd0 || ph == 3'd4);
  assign tx_busy = (ph == 3'd1) || (ph == 3'd2) || (ph == 3'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= 3'd0;
      tx_valid <= 1'b0;
      tx_k     <= 1'b0;
      tx_data  <= '0;
      h1       <= '0;
      h2       <= '0;
      h3       <= '0;
    end else if (accept) begin
      ph       <= 3'd1;
      tx_valid <= 1'b1;
      tx_k     <= 1'b1;
      tx_data  <= CREDIT_K;
      h1       <= {tx_pool, 3'b000, link4};
      h2       <= {4'b0000, fg12[11:8]};
      h3       <= fg12[7:0];
    end else begin
      unique case (ph)
        3'd1: begin
          ph <= 3'd2; tx_k <= 1'b0; tx_data <= h1;
        end
        3'd2: begin
          ph <= 3'd3; tx_data <= h2;
        end
        3'd3: begin
          ph <= 3'd4; tx_data <= h3;
        end
        default: begin
          ph <= 3'd0; tx_valid <= 1'b0; tx_k <= 1'b0; tx_data <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/cg_store.sv
module cg_store #(
  parameter int N_LINKS   = 4,
  parameter int FG_W      = 8,
  parameter int NPRIO     = 3,
  parameter int POOL_INIT = 16,
  parameter int FG_INIT   = 4,
  localparam int LINK_W   = (N_LINKS > 1) ? $clog2(N_LINKS) : 1,
  localparam int PRIO_W   = (NPRIO > 1) ? $clog2(NPRIO) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPRIO-1:0]  bp_en,
  input  logic              req_valid,
  input  logic [LINK_W-1:0] req_link,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic [FG_W-1:0]   req_fg,
  input  logic              cr_valid,
  input  logic              cr_pool,
  input  logic [LINK_W-1:0] cr_link,
  input  logic [FG_W-1:0]   cr_fg,
  output logic              gnt_valid,
  output logic              gnt_ok
);
  localparam int FG_DEPTH = N_LINKS << FG_W;
  localparam int ADDR_W   = LINK_W + FG_W;
  localparam int PW       = $clog2(POOL_INIT + 1);
  localparam int FW       = $clog2(FG_INIT + 1);
  localparam logic [PW-1:0] P_TOP = PW'(POOL_INIT);
  localparam logic [FW-1:0] F_TOP = FW'(FG_INIT);
  localparam logic [LINK_W:0] LINK_LIM = (LINK_W+1)'(N_LINKS);

  logic [PW-1:0] pool_q [N_LINKS];
  logic [FW-1:0] fg_q   [FG_DEPTH];

  logic [ADDR_W-1:0]         ra, ca;
  logic [(1<<PRIO_W)-1:0]    bp_ext;
  logic                      link_ok, bp_cls, has_cr, take, ok;
  logic                      fg_inc, pool_inc, same;

  always_comb begin
    bp_ext = '1;
    bp_ext[NPRIO-1:0] = bp_en;
  end

  assign link_ok  = ({1'b0, req_link} < LINK_LIM);
  assign ra       = {req_link, req_fg};
  assign ca       = {cr_link, cr_fg};
  assign bp_cls   = bp_ext[req_prio];
  assign has_cr   = (pool_q[req_link] != '0) && (fg_q[ra] != '0);
  assign take     = req_valid && link_ok && bp_cls && has_cr;
  assign ok       = req_valid && link_ok && (!bp_cls || has_cr);
  assign fg_inc   = cr_valid && !cr_pool;
  assign pool_inc = cr_valid && cr_pool;
  assign same     = take && fg_inc && (ca == ra);

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_valid <= 1'b0;
      gnt_ok    <= 1'b0;
    end else begin
      gnt_valid <= req_valid;
      gnt_ok    <= ok;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_LINKS; i++) pool_q[i] <= P_TOP;
    end else begin
      for (int i = 0; i < N_LINKS; i++) begin
        if (take && req_link == LINK_W'(i)) begin
          if (!(pool_inc && cr_link == LINK_W'(i)))
            pool_q[i] <= pool_q[i] - PW'(1);
        end else if (pool_inc && cr_link == LINK_W'(i) && pool_q[i] != P_TOP) begin
          pool_q[i] <= pool_q[i] + PW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < FG_DEPTH; j++) fg_q[j] <= F_TOP;
    end else begin
      if (take && !same) fg_q[ra] <= fg_q[ra] - FW'(1);
      if (fg_inc && !same && fg_q[ca] != F_TOP) fg_q[ca] <= fg_q[ca] + FW'(1);
    end
  end
endmodule

// File: rtl/credit_gate.sv
module credit_gate
  import cg_pkg::*;
#(
  parameter int N_LINKS   = 4,
  parameter int FG_W      = 8,
  parameter int NPRIO     = 3,
  parameter int POOL_INIT = 16,
  parameter int FG_INIT   = 4,
  localparam int LINK_W   = (N_LINKS > 1) ? $clog2(N_LINKS) : 1,
  localparam int PRIO_W   = (NPRIO > 1) ? $clog2(NPRIO) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPRIO-1:0]  bp_en,
  input  logic              req_valid,
  input  logic [LINK_W-1:0] req_link,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic [FG_W-1:0]   req_fg,
  output logic              gnt_valid,
  output logic              gnt_ok,
  input  logic              rx_valid,
  input  logic              rx_k,
  input  logic [7:0]        rx_data,
  output logic              rx_err,
  input  logic              tx_req,
  input  logic              tx_pool,
  input  logic [LINK_W-1:0] tx_link,
  input  logic [FG_W-1:0]   tx_fg,
  output logic              tx_valid,
  output logic              tx_k,
  output logic [7:0]        tx_data,
  output logic              tx_busy
);
  logic              cr_valid, cr_pool;
  logic [LINK_W-1:0] cr_link;
  logic [FG_W-1:0]   cr_fg;

  cg_rx_unpack #(.N_LINKS(N_LINKS), .FG_W(FG_W)) u_rx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_k(rx_k), .rx_data(rx_data),
    .cr_valid(cr_valid), .cr_pool(cr_pool), .cr_link(cr_link), .cr_fg(cr_fg),
    .err(rx_err)
  );

  cg_store #(.N_LINKS(N_LINKS), .FG_W(FG_W), .NPRIO(NPRIO),
             .POOL_INIT(POOL_INIT), .FG_INIT(FG_INIT)) u_store (
    .clk(clk), .rst(rst), .bp_en(bp_en), .req_valid(req_valid),
    .req_link(req_link), .req_prio(req_prio), .req_fg(req_fg),
    .cr_valid(cr_valid), .cr_pool(cr_pool), .cr_link(cr_link), .cr_fg(cr_fg),
    .gnt_valid(gnt_valid), .gnt_ok(gnt_ok)
  );

  cg_tx_pack #(.N_LINKS(N_LINKS), .FG_W(FG_W)) u_tx (
    .clk(clk), .rst(rst), .tx_req(tx_req), .tx_pool(tx_pool),
    .tx_link(tx_link), .tx_fg(tx_fg), .tx_valid(tx_valid), .tx_k(tx_k),
    .tx_data(tx_data), .tx_busy(tx_busy)
  );
endmodule

// File: rtl/cg_chk.sv
module cg_chk #(
  parameter int NPRIO  = 3,
  parameter int PRIO_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [NPRIO-1:0]  bp_en,
  input logic              req_valid,
  input logic [PRIO_W-1:0] req_prio,
  input logic              gnt_valid,
  input logic              gnt_ok,
  input logic              rx_valid,
  input logic              rx_err,
  input logic              tx_req,
  input logic              tx_busy,
  input logic              tx_valid,
  input logic              tx_k,
  input logic [7:0]        tx_data
);
  localparam logic [PRIO_W:0] P_LIM = (PRIO_W+1)'(NPRIO);

  logic open_cls;
  always_comb begin
    open_cls = 1'b0;
    for (int i = 0; i < NPRIO; i++)
      if ({1'b0, req_prio} == (PRIO_W+1)'(i) && !bp_en[i]) open_cls = 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!gnt_valid && !tx_valid && !rx_err && !tx_busy)); // R1
  AST_GNT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> gnt_valid); // R2
  AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !gnt_valid); // R2
  AST_OPEN_CLASS_GRANT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ({1'b0, req_prio} < P_LIM) && open_cls) |=> gnt_ok); // R4
  AST_ERR_NEEDS_CHAR: assert property (@(posedge clk) disable iff (rst)
    rx_err |-> $past(rx_valid)); // R8
  AST_TX_HEADER_FIRST: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !tx_busy) |=> (tx_valid && tx_k && tx_data == 8'hC5)); // R9
  AST_TX_DATA_AFTER_HDR: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_k) |=> (tx_valid && !tx_k)); // R9
  AST_TX_BUSY_SENDS: assert property (@(posedge clk) disable iff (rst)
    tx_busy |-> tx_valid); // R9
endmodule

bind credit_gate cg_chk #(.NPRIO(NPRIO), .PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/sim_credit_gate.sv
`timescale 1ns/1ps
module sim_credit_gate;
  localparam int NL = 4, FGW = 4, NP = 3, PINIT = 6, FINIT = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic [NP-1:0] bp_en = 3'b101;
  logic req_valid = 0; logic [1:0] req_link = 0; logic [1:0] req_prio = 0; logic [FGW-1:0] req_fg = 0;
  logic gnt_valid, gnt_ok;
  logic rx_valid = 0, rx_k = 0; logic [7:0] rx_data = 0; logic rx_err;
  logic tx_req = 0, tx_pool = 0; logic [1:0] tx_link = 0; logic [FGW-1:0] tx_fg = 0;
  logic tx_valid, tx_k, tx_busy; logic [7:0] tx_data;

  credit_gate #(.N_LINKS(NL), .FG_W(FGW), .NPRIO(NP), .POOL_INIT(PINIT), .FG_INIT(FINIT)) u0 (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int m_pool [NL];
  int m_fg [NL][1<<FGW];
  bit cr_go = 0, cr_pool_b = 0, exp_err = 0;
  int cr_l = 0, cr_f = 0;
  string cur_tag = "";

  task automatic chk(input bit good, input string rq, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic step();
    bit bp, ok_e; int l, f;
    l = req_link; f = req_fg; ok_e = 0;
    bp = (req_prio >= NP) ? 1'b1 : bp_en[req_prio];
    if (req_valid) begin
      if (!bp) ok_e = 1;
      else if (m_pool[l] > 0 && m_fg[l][f] > 0) begin
        ok_e = 1; m_pool[l]--; m_fg[l][f]--;
      end
    end
    if (cr_go) begin
      if (cr_pool_b) begin if (m_pool[cr_l] < PINIT) m_pool[cr_l]++; end
      else if (m_fg[cr_l][cr_f] < FINIT) m_fg[cr_l][cr_f]++;
    end
    @(posedge clk); #2;
    chk(gnt_valid == req_valid, "R2", gnt_valid, req_valid);
    if (req_valid) chk(gnt_ok == ok_e, (cur_tag != "") ? cur_tag : (bp ? "R2" : "R4"), gnt_ok, ok_e);
    chk(rx_err == exp_err, "R8", rx_err, exp_err);
    cr_go = 0; exp_err = 0;
  endtask

  task automatic req(input int l, input int f, input int p, input string tag);
    req_valid = 1; req_link = 2'(l); req_fg = FGW'(f); req_prio = 2'(p); cur_tag = tag;
    step();
    req_valid = 0; cur_tag = "";
  endtask

  task automatic put_char(input bit k, input logic [7:0] d, input bit e);
    rx_valid = 1; rx_k = k; rx_data = d; exp_err = e;
    step();
    rx_valid = 0; rx_k = 0; rx_data = 0;
  endtask

  task automatic send_credit(input bit pool, input int l, input int f);
    put_char(1, 8'hC5, 0);
    put_char(0, {pool, 3'b000, 4'(l)}, 0);
    put_char(0, {4'b0000, 4'(f >> 8)}, 0);
    cr_go = 1; cr_pool_b = pool; cr_l = l; cr_f = f;
    put_char(0, 8'(f), 0);
  endtask

  task automatic tx_look(input bit v, input bit k, input logic [7:0] d, input bit b);
    @(posedge clk); #2;
    chk(tx_valid == v, "R9", tx_valid, v);
    chk(tx_busy == b, "R9", tx_busy, b);
    if (v) begin
      chk(tx_k == k, "R9", tx_k, k);
      chk(tx_data == d, "R9", tx_data, d);
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int rph, gl, gf, r; bit gp;
    void'($urandom(32'd1234));
    for (int i = 0; i < NL; i++) begin
      m_pool[i] = PINIT;
      for (int j = 0; j < (1 << FGW); j++) m_fg[i][j] = FINIT;
    end
    repeat (3) @(posedge clk);
    #2;
    chk(gnt_valid == 0 && tx_valid == 0 && rx_err == 0 && tx_busy == 0, "R1", gnt_valid, 0);
    rst = 0;
    @(posedge clk); #2;
    chk(gnt_valid == 0 && tx_valid == 0 && rx_err == 0 && tx_busy == 0, "R1", tx_valid, 0);

    // R3 / R5: drain one flow group, then a pool
    for (int i = 0; i < FINIT; i++) req(2, 5, 0, "R3");
    req(2, 5, 0, "R5");
    req(2, 5, 2, "R5");
    for (int i = 0; i < PINIT; i++) req(1, i, 2, "R3");
    req(1, 6, 0, "R5");
    // R4: open class ignores empty counters and takes nothing
    req(1, 6, 1, "R4");
    req(2, 5, 1, "R4");
    req(1, 7, 0, "R5");
    // R6: credits refill exactly one
    send_credit(0, 2, 5);
    req(2, 5, 0, "R6");
    req(2, 5, 0, "R6");
    send_credit(1, 1, 0);
    req(1, 7, 0, "R6");
    req(1, 8, 0, "R6");
    // R7: saturation
    send_credit(0, 3, 0);
    send_credit(0, 3, 0);
    for (int i = 0; i < FINIT; i++) req(3, 0, 0, "R7");
    req(3, 0, 0, "R7");
    // R8: malformed input
    put_char(0, 8'h12, 1);
    put_char(1, 8'hC5, 0);
    put_char(0, 8'h02, 0);
    put_char(1, 8'hC5, 1);
    put_char(0, 8'h02, 0);
    put_char(0, 8'h00, 0);
    cr_go = 1; cr_pool_b = 0; cr_l = 2; cr_f = 5;
    put_char(0, 8'h05, 0);
    req(2, 5, 0, "R8");
    req(2, 5, 0, "R8");
    put_char(1, 8'hC5, 0); put_char(1, 8'h3C, 1); put_char(0, 8'h00, 1);
    put_char(1, 8'hC5, 0); put_char(0, 8'h72, 0); put_char(0, 8'h00, 0); put_char(0, 8'h05, 1);
    req(2, 5, 0, "R8");
    put_char(1, 8'hC5, 0); put_char(0, 8'h02, 0); put_char(0, 8'h01, 0); put_char(0, 8'h05, 1);
    req(2, 5, 0, "R8");
    put_char(1, 8'hC5, 0); put_char(0, 8'h89, 0); put_char(0, 8'h00, 0); put_char(0, 8'h00, 1);
    put_char(1, 8'h3C, 0);
    // R10: grant and credit on one counter in one cycle
    put_char(1, 8'hC5, 0); put_char(0, 8'h00, 0); put_char(0, 8'h00, 0);
    req_valid = 1; req_link = 0; req_fg = 1; req_prio = 0; cur_tag = "R10";
    cr_go = 1; cr_pool_b = 0; cr_l = 0; cr_f = 1;
    put_char(0, 8'h01, 0);
    req_valid = 0; cur_tag = "";
    for (int i = 0; i < FINIT; i++) req(0, 1, 0, "R10");
    req(0, 1, 0, "R10");

    // R9: packing, ignore while busy, back-to-back
    tx_req = 1; tx_pool = 1; tx_link = 2; tx_fg = 4'hB;
    tx_look(1, 1, 8'hC5, 1);
    tx_pool = 0; tx_link = 3; tx_fg = 4'h4;
    tx_look(1, 0, 8'h82, 1);
    tx_look(1, 0, 8'h00, 1);
    tx_look(1, 0, 8'h0B, 0);
    tx_look(1, 1, 8'hC5, 1);
    tx_req = 0;
    tx_look(1, 0, 8'h03, 1);
    tx_look(1, 0, 8'h00, 1);
    tx_look(1, 0, 8'h04, 0);
    tx_look(0, 0, 8'h00, 0);

    // random traffic against the model
    rph = 0; gl = 0; gf = 0; gp = 0;
    for (int c = 0; c < 4000; c++) begin
      req_valid = ($urandom % 10) < 7;
      req_link = 2'($urandom % NL);
      req_fg = FGW'($urandom);
      req_prio = 2'($urandom % NP);
      if (c % 500 == 0) begin
        r = $urandom % 3;
        bp_en = (r == 0) ? 3'b101 : ((r == 1) ? 3'b111 : 3'b010);
      end
      if (rph == 0) begin
        r = $urandom % 16;
        if (r < 4) begin
          rx_valid = 1; rx_k = 1; rx_data = 8'hC5; rph = 1;
          gp = $urandom % 2; gl = $urandom % NL; gf = $urandom % 16;
        end else if (r == 4) begin
          rx_valid = 1; rx_k = 0; rx_data = 8'($urandom); exp_err = 1;
        end
      end else begin
        rx_valid = 1; rx_k = 0;
        if (rph == 1) rx_data = {gp, 3'b000, 4'(gl)};
        else if (rph == 2) rx_data = 8'h00;
        else begin
          rx_data = 8'(gf);
          cr_go = 1; cr_pool_b = gp; cr_l = gl; cr_f = gf;
        end
        rph = (rph == 3) ? 0 : rph + 1;
      end
      step();
      rx_valid = 0; rx_k = 0; rx_data = 0;
    end
    req_valid = 0;
    summary();
    $finish;
  end
endmodule